// File: doc/BRIEF.md
# Packet Hold and Verdict Buffer

This stage sits between the packet parser of a filtering switch and its egress queue. Every arriving packet is written word by word into a packet store while other logic works on its header: a group of parallel security checkers each returns one result with an alert bit, and a forwarding lookup returns an output port. The results may come back in any order and may arrive before the packet's final word has been stored.

Once every checker and the lookup have answered for the oldest unresolved packet, a combined verdict is queued. If no checker raised an alert, the stored packet is sent out with the looked-up port attached to every word. If any checker raised an alert, the packet is read out of the store and thrown away without ever showing on the output, and a discard counter advances. Packets leave in the order they arrived. Intake stops at a packet boundary when the store could not take a packet of maximum length, or when too many packets are still waiting for their verdicts.

Top module: `pkt_verdict_hold`

## Requirements
- R1: Every forwarded packet appears on the output with all of its words unchanged, in the order received, with out_last high on its final word only, and packets leave in arrival order.
- R2: Every word of a forwarded packet carries on out_port the port that the lookup returned for that packet.
- R3: A packet for which at least one checker reported alert = 1 is removed in full: none of its words is presented with out_valid high.
- R4: No word of a packet is presented before all N_CHK checker results and the lookup result for that packet have been received.
- R5: Checker results and the lookup result for a packet may arrive in any order and on any cycles, including before the packet's last word, as long as each source reports once per packet and in packet order.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_last and out_port hold their values.
- R7: Between packets, in_ready is low whenever the packet store holds more than PKT_DEPTH - MAX_PKT words.
- R8: Between packets, in_ready is low whenever VQ_DEPTH packets have been admitted but not yet released or discarded.
- R9: drop_count increases by exactly one for each discarded packet and never otherwise.
- R10: After reset, out_valid is low, in_ready is high and drop_count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | DATA_W | Input packet word |
| in_last | input | 1 | Marks the final word of a packet |
| chk_stb | input | N_CHK | One-cycle result strobe per checker |
| chk_alert | input | N_CHK | Alert bit per checker, valid with its strobe |
| lkp_valid | input | 1 | One-cycle strobe of the forwarding lookup result |
| lkp_port | input | PORT_W | Output port from the lookup, valid with lkp_valid |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output packet word |
| out_last | output | 1 | Marks the final output word of a packet |
| out_port | output | PORT_W | Output port tag of the current packet |
| drop_count | output | CNT_W | Number of discarded packets, wraps |

## Verification
Random traffic mixes packet lengths from one word to the maximum with alert patterns where none, one or several checkers object, so the stream compare separates a correct any-alert merge from one that needs all alerts or looks at a single checker. Result strobes are scattered over cycles in random order and start while the packet is still arriving, which tells apart a merge that waits for every source from one that fires on the first strobe. Random downstream stalls exercise the hold behaviour, and two directed phases with verdicts withheld show intake stopping separately on store space and on the count of packets awaiting a verdict.

// File: rtl/pvh_pkg.sv
// Package: shared types of the packet hold and verdict buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package pvh_pkg;

    // Position of the intake side within the incoming word stream.
    typedef enum logic {
        IN_GAP  = 1'b0,   // next accepted word starts a packet
        IN_BODY = 1'b1    // a packet is partly received
    } in_state_t;

endpackage

// File: rtl/pvh_fifo.sv
// Module: show-ahead synchronous FIFO. The head entry is visible on
// rd_data whenever empty is low; rd_en pops it at the clock edge.
// Assumes: DEPTH is a power of two; callers never write when full
// nor read when empty.
module pvh_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp[AW-1:0]] <= wr_data;
        end
    end

    // Pointer update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
        end
    end

    // Occupancy and flags from the pointer difference.
    always_comb begin
        count   = wp - rp;
        empty   = (count == '0);
        full    = (count == (AW+1)'(DEPTH));
        rd_data = mem[rp[AW-1:0]];
    end

    // R7: intake gating must keep writes away from a full store.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R1: the read side only pops entries that exist.
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/pvh_verdict_merge.sv
// Module: gathers one result from each checker and one lookup port for
// the oldest unresolved packet, then emits a single verdict (discard
// flag plus port) for one cycle and starts over for the next packet.
// Assumes: each source reports once per packet, in packet order, and a
// source does not report for the next packet until the current verdict
// has been emitted.
module pvh_verdict_merge #(
    parameter int N_CHK  = 3,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHK-1:0]  chk_stb,
    input  logic [N_CHK-1:0]  chk_alert,
    input  logic              lkp_valid,
    input  logic [PORT_W-1:0] lkp_port,
    input  logic              vd_full,
    output logic              vd_push,
    output logic              vd_drop,
    output logic [PORT_W-1:0] vd_port
);
    logic [N_CHK-1:0]  seen_q;
    logic [N_CHK-1:0]  alert_q;
    logic              port_have_q;
    logic [PORT_W-1:0] port_q;

    logic [N_CHK-1:0]  seen_nx;
    logic [N_CHK-1:0]  alert_nx;
    logic              have_nx;
    logic [PORT_W-1:0] port_nx;

    // Fold this cycle's strobes into the collected state.
    always_comb begin
        seen_nx  = seen_q | chk_stb;
        alert_nx = alert_q | (chk_stb & chk_alert);
        have_nx  = port_have_q | lkp_valid;
        port_nx  = port_have_q ? port_q : lkp_port;
        vd_push  = (&seen_nx) && have_nx;
        vd_drop  = |alert_nx;
        vd_port  = port_nx;
    end

    // Hold partial results; clear them once a verdict leaves.
    always_ff @(posedge clk) begin
        if (!rst_n || vd_push) begin
            seen_q      <= '0;
            alert_q     <= '0;
            port_have_q <= 1'b0;
            port_q      <= '0;
        end else begin
            seen_q      <= seen_nx;
            alert_q     <= alert_nx;
            port_have_q <= have_nx;
            port_q      <= port_nx;
        end
    end

    // R5: a checker reports only once per packet.
    p_single_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(chk_stb & seen_q)));

    // R5: the lookup reports only once per packet.
    p_single_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |-> !port_have_q);

    // R8: admission limit keeps a slot free for every verdict.
    p_vq_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vd_push |-> !vd_full);

endmodule

// File: rtl/pvh_release.sv
// Module: read side. With a verdict at the head of the verdict queue
// and a word at the head of the packet store, it either presents the
// word downstream (forward) or pops it silently (discard). The verdict
// is retired on the packet's final word.
// Assumes: show-ahead FIFOs on both inputs; packet words carry their
// end marker in the top bit.
module pvh_release #(
    parameter int DATA_W = 32,
    parameter int PORT_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W:0]   pkt_head,
    input  logic              pkt_empty,
    input  logic [PORT_W:0]   vd_head,
    input  logic              vd_empty,
    input  logic              out_ready,
    output logic              pkt_pop,
    output logic              vd_pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [PORT_W-1:0] out_port,
    output logic [CNT_W-1:0]  drop_count
);
    logic active;
    logic head_drop;
    logic head_last;

    // Decide per word whether to present it or discard it.
    always_comb begin
        active    = !vd_empty && !pkt_empty;
        head_drop = vd_head[PORT_W];
        head_last = pkt_head[DATA_W];
        out_valid = active && !head_drop;
        out_data  = pkt_head[DATA_W-1:0];
        out_last  = head_last;
        out_port  = vd_head[PORT_W-1:0];
        pkt_pop   = (out_valid && out_ready) || (active && head_drop);
        vd_pop    = pkt_pop && head_last;
    end

    // Count each discarded packet on its final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (active && head_drop && head_last) begin
            drop_count <= drop_count + 1'b1;
        end
    end

    // R6: a stalled output word is held unchanged.
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_port)));

    // R9: the discard counter moves by at most one per cycle.
    p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == $past(drop_count)) ||
        (drop_count == $past(drop_count) + CNT_W'(1)));

endmodule

// File: rtl/pkt_verdict_hold.sv
// Module: top of the packet hold and verdict buffer. Stores incoming
// packets, merges checker and lookup results into ordered verdicts,
// and releases or discards each stored packet accordingly.
// Assumes: packets are at most MAX_PKT words; result sources follow
// the rules of pvh_verdict_merge and only report on admitted packets.
module pkt_verdict_hold #(
    parameter int DATA_W    = 32,
    parameter int N_CHK     = 3,
    parameter int PORT_W    = 3,
    parameter int PKT_DEPTH = 64,
    parameter int MAX_PKT   = 16,
    parameter int VQ_DEPTH  = 8,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [N_CHK-1:0]  chk_stb,
    input  logic [N_CHK-1:0]  chk_alert,
    input  logic              lkp_valid,
    input  logic [PORT_W-1:0] lkp_port,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [PORT_W-1:0] out_port,
    output logic [CNT_W-1:0]  drop_count
);
    import pvh_pkg::*;

    localparam int PAW = $clog2(PKT_DEPTH);
    localparam int VAW = $clog2(VQ_DEPTH);
    localparam int OW  = $clog2(VQ_DEPTH + 1);
    localparam logic [PAW:0] ADMIT_MAX = (PAW+1)'(PKT_DEPTH - MAX_PKT);

    in_state_t        in_st;
    logic [OW-1:0]    outstanding;
    logic             in_fire;
    logic             pkt_full;
    logic             pkt_empty;
    logic [PAW:0]     pkt_count;
    logic [DATA_W:0]  pkt_head;
    logic             pkt_pop;

    logic             vd_push;
    logic             vd_drop;
    logic [PORT_W-1:0] vd_port;
    logic             vd_full;
    logic             vd_empty;
    logic [VAW:0]     vd_count;
    logic [PORT_W:0]  vd_head;
    logic             vd_pop;

    // Admission: space and verdict slots checked only at a packet start.
    always_comb begin
        if (in_st == IN_BODY) begin
            in_ready = !pkt_full;
        end else begin
            in_ready = (pkt_count <= ADMIT_MAX) && (outstanding < OW'(VQ_DEPTH));
        end
        in_fire = in_valid && in_ready;
    end

    // Track packet boundaries on the intake side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_st <= IN_GAP;
        end else if (in_fire) begin
            in_st <= in_last ? IN_GAP : IN_BODY;
        end
    end

    // Count packets admitted but not yet retired by the read side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else begin
            case ({in_fire && (in_st == IN_GAP), vd_pop})
                2'b10:   outstanding <= outstanding + 1'b1;
                2'b01:   outstanding <= outstanding - 1'b1;
                default: outstanding <= outstanding;
            endcase
        end
    end

    pvh_fifo #(
        .W     (DATA_W + 1),
        .DEPTH (PKT_DEPTH)
    ) u_pkt_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_fire),
        .wr_data ({in_last, in_data}),
        .rd_en   (pkt_pop),
        .rd_data (pkt_head),
        .empty   (pkt_empty),
        .full    (pkt_full),
        .count   (pkt_count)
    );

    pvh_verdict_merge #(
        .N_CHK  (N_CHK),
        .PORT_W (PORT_W)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_stb   (chk_stb),
        .chk_alert (chk_alert),
        .lkp_valid (lkp_valid),
        .lkp_port  (lkp_port),
        .vd_full   (vd_full),
        .vd_push   (vd_push),
        .vd_drop   (vd_drop),
        .vd_port   (vd_port)
    );

    pvh_fifo #(
        .W     (PORT_W + 1),
        .DEPTH (VQ_DEPTH)
    ) u_verdict_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vd_push),
        .wr_data ({vd_drop, vd_port}),
        .rd_en   (vd_pop),
        .rd_data (vd_head),
        .empty   (vd_empty),
        .full    (vd_full),
        .count   (vd_count)
    );

    pvh_release #(
        .DATA_W (DATA_W),
        .PORT_W (PORT_W),
        .CNT_W  (CNT_W)
    ) u_release (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_head   (pkt_head),
        .pkt_empty  (pkt_empty),
        .vd_head    (vd_head),
        .vd_empty   (vd_empty),
        .out_ready  (out_ready),
        .pkt_pop    (pkt_pop),
        .vd_pop     (vd_pop),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_port   (out_port),
        .drop_count (drop_count)
    );

    // R4: a word is only shown while a verdict for it is queued.
    p_gated_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !vd_empty);

    // R8: queued verdicts never exceed the packets awaiting release.
    p_outstanding_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (OW'(vd_count) <= outstanding) && (outstanding <= OW'(VQ_DEPTH)));

endmodule

// File: tb/tb_pkt_verdict_hold.sv
// Bench: directed admission phases followed by seeded random traffic;
// output stream compared against a bench-side model of the packets.
module tb_pkt_verdict_hold;
    localparam int DATA_W = 32;
    localparam int N_CHK  = 3;
    localparam int PORT_W = 3;
    localparam int PKT_DEPTH = 64;
    localparam int MAX_PKT = 16;
    localparam int VQ_DEPTH = 8;
    localparam int CNT_W = 16;
    localparam int NPKT = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic in_last = 1'b0;
    logic [N_CHK-1:0] chk_stb = '0;
    logic [N_CHK-1:0] chk_alert = '0;
    logic lkp_valid = 1'b0;
    logic [PORT_W-1:0] lkp_port = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic out_last;
    logic [PORT_W-1:0] out_port;
    logic [CNT_W-1:0] drop_count;

    always #5 clk = ~clk;

    pkt_verdict_hold #(
        .DATA_W(DATA_W), .N_CHK(N_CHK), .PORT_W(PORT_W), .PKT_DEPTH(PKT_DEPTH),
        .MAX_PKT(MAX_PKT), .VQ_DEPTH(VQ_DEPTH), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .chk_stb(chk_stb), .chk_alert(chk_alert),
        .lkp_valid(lkp_valid), .lkp_port(lkp_port), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .out_port(out_port), .drop_count(drop_count)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int pkt_len [NPKT];
    logic [DATA_W-1:0] pkt_data [NPKT][MAX_PKT];
    logic [N_CHK-1:0] pkt_alert [NPKT];
    logic [PORT_W-1:0] pkt_port [NPKT];

    int started = 0;
    int issued = 0;
    bit res_enable = 0;
    bit mon_en = 0;
    int oi = 0;
    int wi = 0;
    int fwd_recv = 0;

    function automatic bit exp_drop(int k);
        return |pkt_alert[k];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic send_pkt(int k);
        for (int w = 0; w < pkt_len[k]; w++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pkt_data[k][w];
            in_last  = (w == pkt_len[k] - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            if (w == 0) started++;
        end
    endtask

    // Result sources: all checkers and the lookup, scattered in time.
    initial begin
        for (int k = 0; k < NPKT; k++) begin
            logic [N_CHK:0] pending;
            logic [N_CHK:0] pick;
            wait (started > k && res_enable);
            repeat ($urandom % 4) @(negedge clk);
            pending = '1;
            while (pending != '0) begin
                @(negedge clk);
                pick = pending & (N_CHK+1)'($urandom);
                chk_stb   = pick[N_CHK-1:0];
                chk_alert = pick[N_CHK-1:0] & pkt_alert[k];
                lkp_valid = pick[N_CHK];
                lkp_port  = pkt_port[k];
                pending   = pending & ~pick;
            end
            issued++;
            @(negedge clk);
            chk_stb = '0;
            chk_alert = '0;
            lkp_valid = 1'b0;
        end
    end

    // Output monitor with random backpressure.
    bit stall_prev = 0;
    logic [DATA_W-1:0] held_data;
    logic held_last;
    logic [PORT_W-1:0] held_port;
    always @(negedge clk) begin
        if (mon_en) begin
            out_ready = ($urandom % 3) != 0;
            #1;
            if (stall_prev) begin
                check(out_valid && out_data == held_data && out_last == held_last
                      && out_port == held_port, "R6", "stalled word held",
                      int'(out_data), int'(held_data));
            end
            if (out_valid && out_ready) begin
                while (oi < NPKT && exp_drop(oi)) oi++;
                if (oi >= NPKT) begin
                    check(1'b0, "R3", "word beyond expected stream", oi, NPKT);
                end else begin
                    if (wi == 0) check(oi < issued, "R4", "packet shown before verdict", oi, issued);
                    if (out_data != pkt_data[oi][wi] || out_last != (wi == pkt_len[oi]-1)
                        || out_port != pkt_port[oi]) begin
                        n_checks++;
                        n_fail++;
                        $display("FAIL R1 R2 R3 R5 pkt %0d word %0d: actual data %h last %b port %0d expected data %h last %b port %0d",
                                 oi, wi, out_data, out_last, out_port, pkt_data[oi][wi],
                                 (wi == pkt_len[oi]-1), pkt_port[oi]);
                    end else begin
                        n_checks++;
                    end
                    if (wi == pkt_len[oi] - 1) begin
                        wi = 0;
                        oi++;
                        fwd_recv++;
                    end else begin
                        wi++;
                    end
                end
            end
            stall_prev = out_valid && !out_ready;
            held_data = out_data;
            held_last = out_last;
            held_port = out_port;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d packets out expected completion", fwd_recv);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int total_fwd;
        int total_drop;
        void'($urandom(32'd20240611));
        total_fwd = 0;
        total_drop = 0;
        for (int k = 0; k < NPKT; k++) begin
            pkt_len[k] = 1 + ($urandom % MAX_PKT);
            for (int w = 0; w < MAX_PKT; w++) pkt_data[k][w] = $urandom;
            pkt_alert[k] = '0;
            for (int c = 0; c < N_CHK; c++) pkt_alert[k][c] = (($urandom % 8) == 0);
            pkt_port[k] = PORT_W'($urandom);
        end
        // Directed shapes for the admission phases.
        pkt_len[0] = 16; pkt_len[1] = 16; pkt_len[2] = 16; pkt_len[3] = 5;
        pkt_alert[0] = '0;
        pkt_alert[1] = 3'b100;   // only the last checker objects
        pkt_alert[2] = '0;
        pkt_alert[3] = 3'b111;   // all checkers object
        for (int k = 4; k < 12; k++) pkt_len[k] = 1;
        for (int k = 0; k < NPKT; k++) begin
            if (exp_drop(k)) total_drop++; else total_fwd++;
        end

        repeat (4) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
        check(drop_count == '0, "R10", "drop_count after reset", int'(drop_count), 0);
        check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
        mon_en = 1;

        // Phase A: store space limit with verdicts withheld.
        for (int k = 0; k < 4; k++) send_pkt(k);
        idle(1);
        #1;
        check(in_ready == 1'b0, "R7", "in_ready with 53 words stored", int'(in_ready), 0);
        idle(10);
        #1;
        check(out_valid == 1'b0, "R4", "output without verdicts", int'(out_valid), 0);
        res_enable = 1;
        idle(400);

        // Phase B: verdict slot limit with tiny packets.
        res_enable = 0;
        for (int k = 4; k < 12; k++) send_pkt(k);
        idle(1);
        #1;
        check(in_ready == 1'b0, "R8", "in_ready with 8 packets awaiting verdict", int'(in_ready), 0);
        res_enable = 1;
        idle(40);

        // Phase C: random traffic.
        for (int k = 12; k < NPKT; k++) begin
            send_pkt(k);
            idle($urandom % 3);
        end
        idle(1);
        wait (fwd_recv == total_fwd);
        idle(20);
        #1;
        check(drop_count == CNT_W'(total_drop), "R9", "discarded packet count",
              int'(drop_count), total_drop);
        check(out_valid == 1'b0, "R3", "no output after last packet", int'(out_valid), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule